// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface with Detect Interrupt

This block sits on the peripheral side of an 8-bit bus that carries both address and data on the same lines. A host cycle starts with an address strobe. On the falling edge of that strobe the block captures the low three bus bits as a register index. It also captures the chip-select level at the same edge. For the rest of the cycle only this captured select counts; the live chip-select pin is ignored. A write strobe or a read strobe then moves one byte into or out of a small register file. The bus is modelled with separate data-in, data-out and output-enable ports rather than a tri-state pin.

The register file holds two control registers and a tone register, which drive the rest of the design. It also holds a read-only detect register whose bits are sticky flags set by event pulses from the signal path. While any flag is set, the block drives its open-drain interrupt low; this is modelled as a drive-low enable. Completing a read of the detect register clears the flags, and an event in that same cycle survives the clear. The block also produces a clock-output select. That select can choose the sixteen-times data-rate clock only while the control mode field says phase-shift keying. All strobes are sampled on the block clock and act on detected edges.

Top module: `mbus_reg_if`

Register indexes: 0 = control A, 1 = control B, 2 = detect (read-only), 3 = tone, 4 to 7 unused. Control A bits [1:0] hold the mode field, where 2'b01 means phase-shift keyed. Control B bit 7 requests the data-rate clock.

## Requirements
- R1: When `ale` falls, the block captures `ad_in[2:0]` as the register index and `cs_n` as the select for the cycle. Later changes of `cs_n` before the next falling `ale` have no effect.
- R2: While the captured select is low, a rising edge of `wr_n` stores `ad_in` into the indexed register (0, 1 or 3). A later read of that index returns the stored byte.
- R3: While the captured select is high, writes change no register, and `ad_oe` stays 0 even when `rd_n` is low.
- R4: `ad_oe` is 1 exactly while `rd_n` is low and the captured select is low. In that state `ad_out` shows the indexed register.
- R5: A 1 on any bit of `det_set` sets that bit of the detect register. In the next cycle `irq_drive_low` is 1, and a read of index 2 returns the accumulated flags.
- R6: `irq_drive_low` stays 1 until a read of index 2 completes, that is, until `rd_n` rises while the captured select is low. In the cycle after that, the flags are 0 and `irq_drive_low` is 0. Reads of other indexes leave it at 1.
- R7: A `det_set` bit that is high in the same cycle as the clearing read end stays set afterwards, and `irq_drive_low` remains 1.
- R8: Writes to index 2 are ignored. The flags and `irq_drive_low` keep their values.
- R9: `rst` high clears control A, control B, tone and the detect flags. After reset, `irq_drive_low` and `clk_sel` are 0.
- R10: `clk_sel` is 1 only when control B bit 7 is 1 and control A bits [1:0] equal 2'b01. Otherwise it is 0, which selects the crystal clock.
- R11: Indexes 4 to 7 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; index and select are captured when it falls |
| cs_n | input | 1 | Active-low chip select, sampled only when `ale` falls |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; data is taken when it rises |
| ad_in | input | 8 | Bus value seen by the block (index bits or write data) |
| ad_out | output | 8 | Read data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| det_set | input | 8 | Detect event pulses, one per flag |
| irq_drive_low | output | 1 | 1 pulls the open-drain interrupt line low |
| clk_sel | output | 1 | 1 selects the 16x data-rate clock, 0 the crystal clock |
| ctrl_a | output | 8 | Control register A contents |
| ctrl_b | output | 8 | Control register B contents |
| tone | output | 8 | Tone register contents |

## Verification
Writes and reads are run with the captured select low, and each is repeated with the select high while the live pin is held low. This shows that only the select captured by the address strobe gates the bus. Detect pulses are sent one at a time and as several accumulating bits, followed by four cases: a wait, a read of another register, a write to the detect index, and a clearing read that has a new event in its final cycle. Together these show whether the interrupt is sticky, cleared only by the right read, and not lost at the clear. The clock select is tried with each mode field value and across a reset. Unused indexes are written and read back, and the real registers are read afterwards to confirm they did not alias.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam logic [2:0] RIDX_CTRL_A = 3'd0;
    localparam logic [2:0] RIDX_CTRL_B = 3'd1;
    localparam logic [2:0] RIDX_DETECT = 3'd2;
    localparam logic [2:0] RIDX_TONE   = 3'd3;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_PSK = 2'b01,
        MODE_FSK = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;

    localparam int CLKREQ_BIT = 7;
endpackage

// File: rtl/mbus_edge.sv
module mbus_edge #(
    parameter bit IDLE_LEVEL = 1'b1,
    parameter bit FALLING    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic ev_o
);
    typedef struct packed {
        logic last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.last <= IDLE_LEVEL;
        else     st_q      <= st_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign ev_o = st_q.last & ~strobe;
        end else begin : g_rise
            assign ev_o = ~st_q.last & strobe;
        end
    endgenerate
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic          cs_n,
    input  logic [AW-1:0] idx_in,
    output logic [AW-1:0] idx_o,
    output logic          sel_o
);
    typedef struct packed {
        logic [AW-1:0] idx;
        logic          sel;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic    ale_fall;

    mbus_edge #(.IDLE_LEVEL(1'b0), .FALLING(1'b1)) u_ale_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (ale),
        .ev_o   (ale_fall)
    );

    always_comb begin
        st_d = st_q;
        if (ale_fall) begin
            st_d.idx = idx_in;
            st_d.sel = ~cs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.idx <= '0;
            st_q.sel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;
    assign sel_o = st_q.sel;

    a_r1_idx_capture: assert property (@(posedge clk) disable iff (rst)
        ale_fall |=> (idx_o == $past(idx_in)) && (sel_o == !$past(cs_n)));

    a_r1_hold_between: assert property (@(posedge clk) disable iff (rst)
        !ale_fall |=> $stable(sel_o) && $stable(idx_o));
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] idx,
    input  logic          sel,
    input  logic          wr_ev,
    input  logic          rd_end,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] det_set,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl_a_o,
    output logic [DW-1:0] ctrl_b_o,
    output logic [DW-1:0] tone_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] ctrl_a;
        logic [DW-1:0] ctrl_b;
        logic [DW-1:0] tone;
        logic [DW-1:0] det;
    } rf_st_t;

    rf_st_t st_d, st_q;
    logic   det_clear;
    logic   det_wr;

    always_comb begin
        st_d      = st_q;
        det_clear = rd_end && sel && (idx == AW'(RIDX_DETECT));
        det_wr    = wr_ev && sel && (idx == AW'(RIDX_DETECT));
        st_d.det  = (det_clear ? '0 : st_q.det) | det_set;
        if (wr_ev && sel) begin
            case (idx)
                AW'(RIDX_CTRL_A): st_d.ctrl_a = wdata;
                AW'(RIDX_CTRL_B): st_d.ctrl_b = wdata;
                AW'(RIDX_TONE):   st_d.tone   = wdata;
                default:          ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        case (idx)
            AW'(RIDX_CTRL_A): rdata = st_q.ctrl_a;
            AW'(RIDX_CTRL_B): rdata = st_q.ctrl_b;
            AW'(RIDX_DETECT): rdata = st_q.det;
            AW'(RIDX_TONE):   rdata = st_q.tone;
            default:          rdata = '0;
        endcase
    end

    assign ctrl_a_o = st_q.ctrl_a;
    assign ctrl_b_o = st_q.ctrl_b;
    assign tone_o   = st_q.tone;
    assign irq_o    = |st_q.det;

    a_r5_event_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (|det_set) |=> irq_o);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !det_clear) |=> irq_o);

    a_r3_unselected_write: assert property (@(posedge clk) disable iff (rst)
        (wr_ev && !sel) |=> $stable(ctrl_a_o) && $stable(ctrl_b_o) && $stable(tone_o));

    a_r8_detect_readonly: assert property (@(posedge clk) disable iff (rst)
        (det_wr && !det_clear && irq_o) |=> irq_o);
endmodule

// File: rtl/mbus_reg_if.sv
module mbus_reg_if
    import mbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] det_set,
    output logic          irq_drive_low,
    output logic          clk_sel,
    output logic [DW-1:0] ctrl_a,
    output logic [DW-1:0] ctrl_b,
    output logic [DW-1:0] tone
);
    logic [AW-1:0] idx;
    logic          sel;
    logic          wr_rise;
    logic          rd_rise;
    logic [DW-1:0] rdata;

    mbus_addr_latch #(.AW(AW)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .ale    (ale),
        .cs_n   (cs_n),
        .idx_in (ad_in[AW-1:0]),
        .idx_o  (idx),
        .sel_o  (sel)
    );

    mbus_edge #(.IDLE_LEVEL(1'b1), .FALLING(1'b0)) u_wr_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (wr_n),
        .ev_o   (wr_rise)
    );

    mbus_edge #(.IDLE_LEVEL(1'b1), .FALLING(1'b0)) u_rd_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (rd_n),
        .ev_o   (rd_rise)
    );

    mbus_regfile #(.DW(DW), .AW(AW)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx),
        .sel      (sel),
        .wr_ev    (wr_rise),
        .rd_end   (rd_rise),
        .wdata    (ad_in),
        .det_set  (det_set),
        .rdata    (rdata),
        .ctrl_a_o (ctrl_a),
        .ctrl_b_o (ctrl_b),
        .tone_o   (tone),
        .irq_o    (irq_drive_low)
    );

    assign ad_oe   = ~rd_n & sel;
    assign ad_out  = ad_oe ? rdata : '0;
    assign clk_sel = ctrl_b[CLKREQ_BIT] && (mode_e'(ctrl_a[1:0]) == MODE_PSK);

    a_r10_clksel_mode: assert property (@(posedge clk) disable iff (rst)
        clk_sel |-> (ctrl_a[1:0] == 2'b01));

    a_r4_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !rd_n);
endmodule

// File: tb/mbus_reg_if_tb.sv
module mbus_reg_if_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] ad_in = '0;
    logic [7:0] det_set = '0;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       irq_drive_low;
    logic       clk_sel;
    logic [7:0] ctrl_a, ctrl_b, tone;

    int total = 0;
    int bad   = 0;

    string      exp_tag_q[$];
    logic [7:0] exp_val_q[$];
    logic       mon_go = 1'b0;

    always #4 clk = ~clk;

    mbus_reg_if dut_i (
        .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .det_set(det_set),
        .irq_drive_low(irq_drive_low), .clk_sel(clk_sel),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .tone(tone)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value and compares it one ns after the edge
    always @(posedge clk) begin
        #1;
        if (mon_go) begin
            string      t;
            logic [7:0] e;
            t = exp_tag_q.pop_front();
            e = exp_val_q.pop_front();
            chk({t, " oe"}, {7'd0, ad_oe}, 8'h01);
            chk({t, " data"}, ad_out, e);
        end
    end

    task automatic addr_phase(logic [2:0] a, logic cs);
        @(negedge clk);
        ad_in = {5'd0, a};
        cs_n  = cs;
        ale   = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
        cs_n = ~cs;
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] v, logic cs);
        addr_phase(a, cs);
        ad_in = v;
        wr_n  = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(logic [2:0] a, logic [7:0] exp, string tag, logic [7:0] evt);
        addr_phase(a, 1'b0);
        rd_n = 1'b0;
        exp_tag_q.push_back(tag);
        exp_val_q.push_back(exp);
        mon_go = 1'b1;
        @(negedge clk);
        mon_go  = 1'b0;
        rd_n    = 1'b1;
        det_set = evt;
        @(negedge clk);
        det_set = '0;
    endtask

    task automatic pulse_det(logic [7:0] v);
        @(negedge clk);
        det_set = v;
        @(negedge clk);
        det_set = '0;
    endtask

    initial begin
        #1_600_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 ctrl_a", ctrl_a, 8'h00);
        chk("R9 ctrl_b", ctrl_b, 8'h00);
        chk("R9 tone", tone, 8'h00);
        chk("R9 irq", {7'd0, irq_drive_low}, 8'h00);
        chk("R9 clk_sel", {7'd0, clk_sel}, 8'h00);

        // R2 writes and read-back, mode FSK
        bus_wr(3'd0, 8'h5A, 1'b0);
        bus_wr(3'd1, 8'h80, 1'b0);
        bus_wr(3'd3, 8'h3C, 1'b0);
        bus_rd(3'd0, 8'h5A, "R2 ctrl_a", 8'h00);
        bus_rd(3'd1, 8'h80, "R2 ctrl_b", 8'h00);
        bus_rd(3'd3, 8'h3C, "R4 tone", 8'h00);
        chk("R2 tone port", tone, 8'h3C);
        chk("R10 fsk crystal", {7'd0, clk_sel}, 8'h00);

        // R10 PSK mode enables the rate clock
        bus_wr(3'd0, 8'h01, 1'b0);
        chk("R10 psk rate clk", {7'd0, clk_sel}, 8'h01);
        bus_wr(3'd0, 8'h03, 1'b0);
        chk("R10 reserved crystal", {7'd0, clk_sel}, 8'h00);
        bus_wr(3'd0, 8'h01, 1'b0);
        bus_wr(3'd1, 8'h00, 1'b0);
        chk("R10 no request", {7'd0, clk_sel}, 8'h00);
        bus_wr(3'd1, 8'h80, 1'b0);

        // R3 / R1: captured select high, live pin low during strobe
        bus_wr(3'd3, 8'hFF, 1'b1);
        chk("R3 tone kept", tone, 8'h3C);
        addr_phase(3'd3, 1'b1);
        rd_n = 1'b0;
        #2;
        chk("R3 oe off", {7'd0, ad_oe}, 8'h00);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R4 oe idle", {7'd0, ad_oe}, 8'h00);
        bus_rd(3'd3, 8'h3C, "R1 latched sel", 8'h00);

        // R11 unused index
        bus_wr(3'd5, 8'h77, 1'b0);
        bus_rd(3'd5, 8'h00, "R11 unused", 8'h00);
        bus_rd(3'd0, 8'h01, "R11 ctrl_a kept", 8'h00);
        bus_rd(3'd1, 8'h80, "R11 ctrl_b kept", 8'h00);

        // R5 / R8 / R6
        pulse_det(8'h04);
        chk("R5 irq set", {7'd0, irq_drive_low}, 8'h01);
        pulse_det(8'h10);
        bus_wr(3'd2, 8'h00, 1'b0);
        chk("R8 irq kept", {7'd0, irq_drive_low}, 8'h01);
        bus_rd(3'd2, 8'h14, "R5 flags", 8'h00);
        chk("R6 irq cleared", {7'd0, irq_drive_low}, 8'h00);
        bus_rd(3'd2, 8'h00, "R6 flags cleared", 8'h00);

        // R7 event at clear edge
        pulse_det(8'h01);
        bus_rd(3'd2, 8'h01, "R7 first", 8'h20);
        chk("R7 irq kept", {7'd0, irq_drive_low}, 8'h01);
        bus_rd(3'd2, 8'h20, "R7 new flag", 8'h00);
        chk("R7 irq cleared", {7'd0, irq_drive_low}, 8'h00);

        // R6 hold across wait and other read
        pulse_det(8'h02);
        repeat (10) @(negedge clk);
        chk("R6 hold wait", {7'd0, irq_drive_low}, 8'h01);
        bus_rd(3'd3, 8'h3C, "R6 other read", 8'h00);
        chk("R6 hold other", {7'd0, irq_drive_low}, 8'h01);

        // R9 reset with pending flag and PSK request
        chk("R9 pre clk_sel", {7'd0, clk_sel}, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 irq after rst", {7'd0, irq_drive_low}, 8'h00);
        chk("R9 clk_sel after rst", {7'd0, clk_sel}, 8'h00);
        chk("R9 ctrl_a after rst", ctrl_a, 8'h00);
        chk("R9 tone after rst", tone, 8'h00);
        bus_rd(3'd2, 8'h00, "R9 flags after rst", 8'h00);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule